// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Pull-Up Resolution and Change Listeners

This block is a general-purpose I/O port of sixteen pins placed behind a small register bus. One 32-bit control word holds, for every pin, an output-enable bit and a pull-up enable bit. A 16-bit data register holds the value the CPU drives. Every pin is also driven by an external peripheral through a direction vector and a data vector. The level seen on each pin is resolved from three sources: the CPU drive, the peripheral drive, and the pull-up when nobody drives.

Whenever software writes the control or the data register, the port compares the resolved levels just before and just after that write. The changed bits go through a trigger mask for each listener slot. Every valid slot whose mask covers a changed bit gets a single-cycle notify strobe. A third register, for pin-change interrupt control, exists only so that a non-zero setting can be refused: it raises an error.

The request side follows valid/ready rules. `bus_ready` is tied high, so a request is taken in any cycle in which `bus_valid` is high. A read response is given one cycle later on `rsp_valid`/`rsp_rdata`. The response has no ready, so the consumer must take it in the cycle it appears.

Top module: `gpio_pullup_port`

## Requirements
- R1: After reset, every control, data and interrupt-control bit is zero. All pins resolve to 0, `notify` is 0, and a read of the control word returns 0.
- R2: In the control word at offset 0x0, bit 2n enables the CPU output on pin n and bit 2n+1 enables the pull-up on pin n. A read of the control word returns the last value written to it.
- R3: Pin n resolves to 1 in either of two cases: the CPU drives it (output enabled and data bit 1), or the peripheral drives it (direction bit 1 and data bit 1). It also resolves to 1 when neither side drives it and its pull-up is enabled. In every other case it is 0. `pin_level` shows these resolved levels at all times.
- R4: A read of the data register at offset 0x4 returns the resolved pin levels, zero-extended, and not the value last written.
- R5: A write to the control or data register that leaves every resolved level unchanged raises no notify strobe.
- R6: Some writes to the control or data register change resolved levels. In the cycle after such a write, `notify_changed` holds old XOR new levels. `notify[i]` pulses for exactly one cycle when slot i is valid and its mask shares a bit with the changed bits.
- R7: A slot whose `listener_valid` bit is 0 is never notified, whatever its mask.
- R8: The control word takes only 32-bit accesses (`bus_size` = 2). The data and interrupt-control registers take only 16-bit accesses (`bus_size` = 1). Any other size, or an unmapped offset, changes no state, returns 0 on a read, and pulses `bus_err` in the following cycle.
- R9: A 16-bit write of a non-zero value to the interrupt-control register at offset 0x8 pulses `bus_err` in the following cycle. A zero write does not.
- R10: A change of the peripheral inputs with no register write changes `pin_level` at once but raises no notify strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request ready, always 1 |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_size | input | 2 | Access size: 1 = 16-bit, 2 = 32-bit |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata | output | 32 | Read response data |
| bus_err | output | 1 | One-cycle pulse after an erroneous access |
| periph_dir | input | 16 | Peripheral drive enables, one per pin |
| periph_data | input | 16 | Peripheral drive values |
| listener_valid | input | 4 | Listener slot valid flags |
| listener_mask | input | 64 | Trigger masks, slot i at bits [16i+15:16i] |
| pin_level | output | 16 | Resolved pin levels |
| notify | output | 4 | Per-listener notify strobes |
| notify_changed | output | 16 | Changed-bit vector for the strobe cycle |

## Verification
On every cycle, the assertions check three things. Undriven pins follow their pull-ups. Notify strobes appear only in the cycle after a port write, never for an invalid slot, and never with an empty changed vector. The interrupt-control and bad-size rules raise the error, and a bad-size control write leaves the register unchanged. Only the bench's scenarios can show the rest: the exact changed-bit vector and the per-slot masking against a model, the data read returning resolved levels rather than the written value, the one-cycle width of each strobe, and the silence when peripheral inputs move with no write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_IRQC = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_line_resolve.sv
module gpio_line_resolve #(
  parameter int unsigned NPINS = 16
) (
  input  logic [NPINS-1:0] cpu_dir,
  input  logic [NPINS-1:0] cpu_data,
  input  logic [NPINS-1:0] per_dir,
  input  logic [NPINS-1:0] per_data,
  input  logic [NPINS-1:0] pull_en,
  output logic [NPINS-1:0] level
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic cpu_drv, per_drv, floating;
    always_comb begin
      cpu_drv  = cpu_dir[n] & cpu_data[n];
      per_drv  = per_dir[n] & per_data[n];
      floating = ~(cpu_dir[n] | per_dir[n]);
      level[n] = cpu_drv | per_drv | (floating & pull_en[n]);
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS    = 16,
  parameter int unsigned AW       = 4,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned DATA_OFS = 4,
  parameter int unsigned IRQC_OFS = 8,
  parameter int unsigned IRQC_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [AW-1:0]      bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic [NPINS-1:0]   pin_now,
  output logic [NPINS-1:0]   dir_q,
  output logic [NPINS-1:0]   pull_q,
  output logic [NPINS-1:0]   data_q,
  output logic [NPINS-1:0]   dir_nx,
  output logic [NPINS-1:0]   pull_nx,
  output logic [NPINS-1:0]   data_nx,
  output logic               port_wr,
  output logic               rsp_valid,
  output logic [BUS_W-1:0]   rsp_rdata,
  output logic               bus_err
);
  localparam int unsigned CW = 2 * NPINS;

  reg_sel_e          sel;
  logic              size_ok, acc_ok;
  logic              ctl_wr, data_wr, irqc_wr, err_now;
  logic [CW-1:0]     ctl_q, ctl_src;
  logic [IRQC_W-1:0] irqc_q;
  logic [BUS_W-1:0]  rd_mux;

  always_comb begin
    if (bus_addr == AW'(CTRL_OFS))      sel = SEL_CTRL;
    else if (bus_addr == AW'(DATA_OFS)) sel = SEL_DATA;
    else if (bus_addr == AW'(IRQC_OFS)) sel = SEL_IRQC;
    else                                sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: size_ok = (bus_size == SZ_WORD);
      SEL_DATA: size_ok = (bus_size == SZ_HALF);
      SEL_IRQC: size_ok = (bus_size == SZ_HALF);
      default:  size_ok = 1'b0;
    endcase
    acc_ok  = bus_valid & size_ok;
    ctl_wr  = acc_ok & bus_write & (sel == SEL_CTRL);
    data_wr = acc_ok & bus_write & (sel == SEL_DATA);
    irqc_wr = acc_ok & bus_write & (sel == SEL_IRQC);
    err_now = bus_valid & (~size_ok | (irqc_wr & (bus_wdata[IRQC_W-1:0] != '0)));
    port_wr = ctl_wr | data_wr;
  end

  always_comb begin
    ctl_src = ctl_wr  ? bus_wdata[CW-1:0]    : ctl_q;
    data_nx = data_wr ? bus_wdata[NPINS-1:0] : data_q;
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_split
    always_comb begin
      dir_q[n]   = ctl_q[2*n];
      pull_q[n]  = ctl_q[2*n+1];
      dir_nx[n]  = ctl_src[2*n];
      pull_nx[n] = ctl_src[2*n+1];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (size_ok) begin
      unique case (sel)
        SEL_CTRL: rd_mux = BUS_W'(ctl_q);
        SEL_DATA: rd_mux = BUS_W'(pin_now);
        SEL_IRQC: rd_mux = BUS_W'(irqc_q);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      data_q    <= '0;
      irqc_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      ctl_q     <= ctl_src;
      data_q    <= data_nx;
      if (irqc_wr) irqc_q <= bus_wdata[IRQC_W-1:0];
      rsp_valid <= bus_valid & ~bus_write;
      rsp_rdata <= (bus_valid & ~bus_write) ? rd_mux : '0;
      bus_err   <= err_now;
    end
  end

  // R9
  irqc_nonzero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_valid && bus_write && bus_addr == AW'(IRQC_OFS) &&
          bus_size == SZ_HALF && bus_wdata[IRQC_W-1:0] != '0) |-> bus_err);

  // R8
  ctrl_badsize_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_valid && bus_write && bus_addr == AW'(CTRL_OFS) && bus_size != SZ_WORD)
      |-> ($stable(dir_q) && $stable(pull_q) && bus_err));
endmodule

// File: rtl/gpio_change_notify.sv
module gpio_change_notify #(
  parameter int unsigned NPINS = 16,
  parameter int unsigned NLIST = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   port_wr,
  input  logic [NPINS-1:0]       lvl_old,
  input  logic [NPINS-1:0]       lvl_new,
  input  logic [NLIST-1:0]       lst_valid,
  input  logic [NLIST*NPINS-1:0] lst_mask,
  output logic [NLIST-1:0]       notify,
  output logic [NPINS-1:0]       changed_q
);
  logic [NPINS-1:0] delta;
  logic [NLIST-1:0] hit;

  assign delta = lvl_old ^ lvl_new;

  for (genvar i = 0; i < NLIST; i++) begin : g_slot
    always_comb hit[i] = port_wr & lst_valid[i] & (|(lst_mask[i*NPINS +: NPINS] & delta));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notify    <= '0;
      changed_q <= '0;
    end else begin
      notify    <= hit;
      changed_q <= port_wr ? delta : '0;
    end
  end

  // R6
  notify_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|notify) |-> $past(port_wr));

  // R7
  notify_valid_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (notify & ~$past(lst_valid)) == '0);

  // R5
  notify_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|notify) |-> (changed_q != '0));
endmodule

// File: rtl/gpio_pullup_port.sv
module gpio_pullup_port #(
  parameter int unsigned NPINS = 16,
  parameter int unsigned NLIST = 4,
  parameter int unsigned AW    = 4,
  parameter int unsigned BUS_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  output logic                   bus_ready,
  input  logic                   bus_write,
  input  logic [AW-1:0]          bus_addr,
  input  logic [1:0]             bus_size,
  input  logic [BUS_W-1:0]       bus_wdata,
  output logic                   rsp_valid,
  output logic [BUS_W-1:0]       rsp_rdata,
  output logic                   bus_err,
  input  logic [NPINS-1:0]       periph_dir,
  input  logic [NPINS-1:0]       periph_data,
  input  logic [NLIST-1:0]       listener_valid,
  input  logic [NLIST*NPINS-1:0] listener_mask,
  output logic [NPINS-1:0]       pin_level,
  output logic [NLIST-1:0]       notify,
  output logic [NPINS-1:0]       notify_changed
);
  logic [NPINS-1:0] dir_q, pull_q, data_q, dir_nx, pull_nx, data_nx;
  logic [NPINS-1:0] lvl_cur, lvl_nxt;
  logic             port_wr;

  assign bus_ready = 1'b1;
  assign pin_level = lvl_cur;

  gpio_port_regs #(.NPINS(NPINS), .AW(AW), .BUS_W(BUS_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .pin_now(lvl_cur),
    .dir_q(dir_q), .pull_q(pull_q), .data_q(data_q),
    .dir_nx(dir_nx), .pull_nx(pull_nx), .data_nx(data_nx),
    .port_wr(port_wr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_err(bus_err)
  );

  gpio_line_resolve #(.NPINS(NPINS)) res_cur_i (
    .cpu_dir(dir_q), .cpu_data(data_q), .per_dir(periph_dir),
    .per_data(periph_data), .pull_en(pull_q), .level(lvl_cur)
  );

  gpio_line_resolve #(.NPINS(NPINS)) res_nxt_i (
    .cpu_dir(dir_nx), .cpu_data(data_nx), .per_dir(periph_dir),
    .per_data(periph_data), .pull_en(pull_nx), .level(lvl_nxt)
  );

  gpio_change_notify #(.NPINS(NPINS), .NLIST(NLIST)) chg_i (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr),
    .lvl_old(lvl_cur), .lvl_new(lvl_nxt),
    .lst_valid(listener_valid), .lst_mask(listener_mask),
    .notify(notify), .changed_q(notify_changed)
  );

  // R3
  pullup_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_level ^ pull_q) & ~(dir_q | periph_dir)) == '0);
endmodule

// File: tb/gpio_pullup_port_tb.sv
`timescale 1ns/1ps
module gpio_pullup_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic        bus_ready;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid, bus_err;
  logic [31:0] rsp_rdata;
  logic [15:0] periph_dir = '0, periph_data = '0;
  logic [3:0]  listener_valid = '0;
  logic [63:0] listener_mask = '0;
  logic [15:0] pin_level, notify_changed;
  logic [3:0]  notify;

  int checks = 0;
  int fails = 0;

  logic [31:0] ctl_m = '0;
  logic [15:0] data_m = '0;
  logic [15:0] irq_m = '0;

  always #4 clk = ~clk;

  gpio_pullup_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_err(bus_err), .periph_dir(periph_dir), .periph_data(periph_data),
    .listener_valid(listener_valid), .listener_mask(listener_mask),
    .pin_level(pin_level), .notify(notify), .notify_changed(notify_changed)
  );

  function automatic logic [15:0] resolve(logic [31:0] c, logic [15:0] d,
                                          logic [15:0] pd, logic [15:0] pv);
    logic [15:0] r;
    for (int n = 0; n < 16; n++)
      r[n] = (c[2*n] & d[n]) | (pd[n] & pv[n]) | (~(c[2*n] | pd[n]) & c[2*n+1]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // One request cycle followed by one idle cycle, checked against the model.
  task automatic bus_op(input bit wr, input logic [3:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd);
    logic [15:0] old_l, new_l, chg;
    logic [3:0]  exp_n;
    logic [31:0] exp_rd;
    bit ok_sz, exp_err, port_w;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_size = sz; bus_wdata = wd;
    ok_sz = (addr == 4'h0 && sz == 2'd2) || ((addr == 4'h4 || addr == 4'h8) && sz == 2'd1);
    old_l = resolve(ctl_m, data_m, periph_dir, periph_data);
    exp_rd = '0;
    if (ok_sz && !wr) begin
      if (addr == 4'h0) exp_rd = ctl_m;
      else if (addr == 4'h4) exp_rd = {16'h0, old_l};
      else exp_rd = {16'h0, irq_m};
    end
    exp_err = !ok_sz;
    port_w = 1'b0;
    if (ok_sz && wr) begin
      if (addr == 4'h0) begin ctl_m = wd; port_w = 1'b1; end
      else if (addr == 4'h4) begin data_m = wd[15:0]; port_w = 1'b1; end
      else begin irq_m = wd[15:0]; exp_err = (wd[15:0] != 0); end
    end
    new_l = resolve(ctl_m, data_m, periph_dir, periph_data);
    chg = port_w ? (old_l ^ new_l) : 16'h0;
    for (int i = 0; i < 4; i++)
      exp_n[i] = port_w && listener_valid[i] && ((listener_mask[i*16 +: 16] & chg) != 0);
    chk(bus_ready === 1'b1, "R8 ready", {31'h0, bus_ready}, 32'h1);
    @(posedge clk); #1;
    chk(bus_err === exp_err, exp_err && ok_sz ? "R9 err" : "R8 err",
        {31'h0, bus_err}, {31'h0, exp_err});
    chk(rsp_valid === !wr, "R8 rsp_valid", {31'h0, rsp_valid}, {31'h0, !wr});
    if (!wr) chk(rsp_rdata === exp_rd, addr == 4'h4 ? "R4 data read" : "R2 read",
                 rsp_rdata, exp_rd);
    chk(pin_level === new_l, "R3 pin_level", {16'h0, pin_level}, {16'h0, new_l});
    chk(notify === exp_n, chg == 0 ? "R5 notify" : "R6 notify",
        {28'h0, notify}, {28'h0, exp_n});
    if (port_w) chk(notify_changed === chg, "R6 changed", {16'h0, notify_changed}, {16'h0, chg});
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    @(posedge clk); #1;
    chk(notify === 4'h0, "R6 pulse width", {28'h0, notify}, 32'h0);
    chk(bus_err === 1'b0, "R9 err idle", {31'h0, bus_err}, 32'h0);
  endtask

  // R10: move peripheral inputs with no write
  task automatic periph_move(input logic [15:0] pd, input logic [15:0] pv);
    logic [15:0] e;
    @(negedge clk);
    periph_dir = pd; periph_data = pv;
    #1;
    e = resolve(ctl_m, data_m, periph_dir, periph_data);
    chk(pin_level === e, "R10 level follows", {16'h0, pin_level}, {16'h0, e});
    @(posedge clk); #1;
    chk(notify === 4'h0, "R10 no notify", {28'h0, notify}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk(pin_level === 16'h0, "R1 pins", {16'h0, pin_level}, 32'h0);
    chk(notify === 4'h0, "R1 notify", {28'h0, notify}, 32'h0);
    bus_op(1'b0, 4'h0, 2'd2, 32'h0);
    bus_op(1'b0, 4'h4, 2'd1, 32'h0);

    @(negedge clk);
    listener_valid = 4'b1011;
    listener_mask  = {16'hF000, 16'h0001, 16'hFFFF, 16'h00FF};
    // R2 all pull-ups (odd bits): all pins high, slot 2 invalid (R7)
    bus_op(1'b1, 4'h0, 2'd2, 32'hAAAA_AAAA);
    bus_op(1'b0, 4'h0, 2'd2, 32'h0);
    // R5 same value again: no change
    bus_op(1'b1, 4'h0, 2'd2, 32'hAAAA_AAAA);
    // R4 data write with all outputs disabled: read shows pull-ups
    bus_op(1'b1, 4'h4, 2'd1, 32'h0000_1234);
    bus_op(1'b0, 4'h4, 2'd1, 32'h0);
    // R2 enable output on pin 0 only (even bit 0): pin 0 goes low
    bus_op(1'b1, 4'h0, 2'd2, 32'hAAAA_AAAB);
    // R6 pin 15 output on, data bit15=0 -> only slot 3 and 1
    bus_op(1'b1, 4'h0, 2'd2, 32'hEAAA_AAAB);
    // R8 bad sizes and unmapped offset
    bus_op(1'b1, 4'h0, 2'd1, 32'h0);
    bus_op(1'b1, 4'h4, 2'd2, 32'hFFFF_FFFF);
    bus_op(1'b0, 4'hC, 2'd1, 32'h0);
    bus_op(1'b0, 4'h0, 2'd2, 32'h0);
    // R9 interrupt control
    bus_op(1'b1, 4'h8, 2'd1, 32'h0000_0000);
    bus_op(1'b1, 4'h8, 2'd1, 32'h0000_0004);
    bus_op(1'b0, 4'h8, 2'd1, 32'h0);
    bus_op(1'b1, 4'h8, 2'd1, 32'h0);
    // R10 peripheral drives pin 3 without a write
    periph_move(16'h0008, 16'h0000);
    periph_move(16'h0008, 16'h0008);

    for (int k = 0; k < 600; k++) begin
      logic [3:0] a;
      logic [1:0] s;
      logic [31:0] w;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 4) ? 4'h0 : (pick < 8) ? 4'h4 : (pick == 8) ? 4'h8 : 4'hC;
      s = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(0, 3))
                                      : ((a == 4'h0) ? 2'd2 : 2'd1);
      w = $urandom();
      if (a == 4'h8 && $urandom_range(0, 3) != 0) w = 32'h0;
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk);
        listener_valid = 4'($urandom());
        listener_mask = {$urandom(), $urandom()};
      end
      if ($urandom_range(0, 4) == 0)
        periph_move(16'($urandom()), 16'($urandom()));
      bus_op($urandom_range(0, 2) != 0, a, s, w);
    end
    finish_run();
  end
endmodule